// File: doc/BRIEF.md
# Wormhole Crossbar Switch

A fourteen-port crossbar that carries frames of 128-bit words from any input port to any output channel. The first word of every frame is a routing word: the switch reads a channel number and a parity bit from its low bits, claims the named output, and then discards the routing word. Every later word passes through unchanged until the word flagged as last has been accepted downstream, and only then is the output released. Because the routing word is removed, the next word of the frame can serve as the routing word of a further switch, so switches cascade to any depth by stacking one routing word per hop.

Each port uses a valid/ready handshake with a last-word flag. When several inputs ask for the same free output in one cycle, a round-robin arbiter for that output picks one. The others wait with ready low. A routing word that names a channel that does not exist, or that fails its parity check, causes the whole frame to be swallowed and an error pulse to be raised on that input.

Top module: `xbar_wormhole_switch`

## Requirements
- R1: After reset, with no input valid, every in_ready_o bit, every out_valid_o bit and every err_o bit is low.
- R2: The routing word carries the channel number in bits [3:0] and a parity bit in bit 4, chosen so that the XOR of bits [4:0] is 0. A good routing word is consumed and never shown at an output. Every following word of the frame appears on the chosen output's out_data_o bit for bit, with its last flag, in the order sent.
- R3: An output stays bound to its input until a word with out_last_o is accepted there (out_valid_o and out_ready_i high). The output is free from the next cycle on.
- R4: Each output has a round-robin pointer that starts at input 0. Among inputs requesting that free output in one cycle, the first at or after the pointer, wrapping upward, wins. After a grant to input k, the pointer moves to k+1.
- R5: While an output is bound, or while an input loses arbitration, a waiting input's in_ready_o stays low and its routing word stays unconsumed. An input is bound to at most one output at a time.
- R6: A routing word whose channel is 14 or 15, or whose parity is odd, is accepted along with every word of its frame up to the last (ready high). Nothing is forwarded, and err_o for that input is high for exactly the one cycle after the routing word is accepted.
- R7: While a path is open, the input's in_ready_o follows out_ready_i of its output, so a stalled output stalls its input with no word lost.
- R8: A good routing word that also carries the last flag is accepted at once without arbitration. Nothing is forwarded, no output is bound, and no error is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 14 | Per-input word valid |
| in_data_i | input | 14x128 | Per-input word |
| in_last_i | input | 14 | Per-input last-word flag |
| in_ready_o | output | 14 | Per-input ready |
| out_valid_o | output | 14 | Per-output word valid |
| out_data_o | output | 14x128 | Per-output word |
| out_last_o | output | 14 | Per-output last-word flag |
| out_ready_i | input | 14 | Per-output ready from downstream |
| err_o | output | 14 | Per-input one-cycle bad-route pulse |

## Verification
On every cycle the assertions check the following: a bound output keeps its owner until its close word is accepted and is free right after; an input never holds two outputs; a frame being discarded owns no output; and grants go only to inputs that are asking. Arbitration order, the exact data carried, the length of the error pulse, backpressure propagation and the behaviour of routing words that carry the last flag can only be shown by the bench. It runs a behavioural model of the handshakes and checks its scenarios: contention, stalled outputs, bad routes, cascaded routing words and mixed random traffic.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  typedef enum logic [1:0] {
    ST_HEAD = 2'd0,
    ST_FWD  = 2'd1,
    ST_DROP = 2'd2
  } in_st_e;
endpackage

// File: rtl/xbar_rr_arb.sv
module xbar_rr_arb #(
  parameter int N_PORTS = 14
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [N_PORTS-1:0] req_i,
  output logic [N_PORTS-1:0] gnt_o
);
  localparam int IDX_W = $clog2(N_PORTS);

  logic [IDX_W-1:0] ptr_q;
  logic             found;
  logic [IDX_W-1:0] win;

  always_comb begin
    gnt_o = '0;
    found = 1'b0;
    win   = '0;
    for (int k = 0; k < N_PORTS; k++) begin
      int idx;
      idx = int'(ptr_q) + k;
      if (idx >= N_PORTS) idx = idx - N_PORTS;
      if (en_i && !found && req_i[idx]) begin
        found      = 1'b1;
        gnt_o[idx] = 1'b1;
        win        = IDX_W'(idx);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_q <= '0;
    else if (found) ptr_q <= (int'(win) == N_PORTS-1) ? '0 : win + 1'b1;
  end
endmodule

// File: rtl/xbar_in_ctl.sv
module xbar_in_ctl import xbar_pkg::*; #(
  parameter int N_PORTS = 14
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         valid_i,
  input  logic                         last_i,
  input  logic [$clog2(N_PORTS):0]     route_i,
  input  logic                         gnt_i,
  input  logic                         path_ready_i,
  output logic                         ready_o,
  output logic                         req_o,
  output logic [$clog2(N_PORTS)-1:0]   req_ch_o,
  output logic [$clog2(N_PORTS)-1:0]   lock_ch_o,
  output logic                         drop_o,
  output logic                         err_o
);
  localparam int IDX_W = $clog2(N_PORTS);

  in_st_e           st_q, st_d;
  logic [IDX_W-1:0] lock_q;
  logic             bad, head, skip;

  assign bad      = (int'(route_i[IDX_W-1:0]) >= N_PORTS) || (^route_i);
  assign head     = (st_q == ST_HEAD);
  assign skip     = head && valid_i && (bad || last_i);
  assign req_o    = head && valid_i && !bad && !last_i;
  assign req_ch_o = route_i[IDX_W-1:0];
  assign lock_ch_o = lock_q;
  assign drop_o   = (st_q == ST_DROP);

  always_comb begin
    unique case (st_q)
      ST_HEAD: ready_o = skip || gnt_i;
      ST_FWD:  ready_o = path_ready_i;
      default: ready_o = 1'b1;
    endcase
  end

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_HEAD: if (valid_i && bad && !last_i) st_d = ST_DROP;
               else if (gnt_i)                st_d = ST_FWD;
      ST_FWD:  if (valid_i && path_ready_i && last_i) st_d = ST_HEAD;
      default: if (valid_i && last_i) st_d = ST_HEAD;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_HEAD;
      lock_q <= '0;
      err_o  <= 1'b0;
    end else begin
      st_q  <= st_d;
      err_o <= head && valid_i && bad;
      if (head && gnt_i) lock_q <= req_ch_o;
    end
  end

  // R4
  grant_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_i |-> req_o);
endmodule

// File: rtl/xbar_wormhole_switch.sv
module xbar_wormhole_switch import xbar_pkg::*; #(
  parameter int N_PORTS = 14,
  parameter int DATA_W  = 128
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [N_PORTS-1:0]              in_valid_i,
  input  logic [N_PORTS-1:0][DATA_W-1:0]  in_data_i,
  input  logic [N_PORTS-1:0]              in_last_i,
  output logic [N_PORTS-1:0]              in_ready_o,
  output logic [N_PORTS-1:0]              out_valid_o,
  output logic [N_PORTS-1:0][DATA_W-1:0]  out_data_o,
  output logic [N_PORTS-1:0]              out_last_o,
  input  logic [N_PORTS-1:0]              out_ready_i,
  output logic [N_PORTS-1:0]              err_o
);
  localparam int IDX_W = $clog2(N_PORTS);

  logic [N_PORTS-1:0]                req, gnt_in, path_rdy, drop;
  logic [N_PORTS-1:0][IDX_W-1:0]     req_ch, lock_ch;
  logic [N_PORTS-1:0][N_PORTS-1:0]   arb_req, arb_gnt;   // [out][in]
  logic [N_PORTS-1:0]                own_vld, close;
  logic [N_PORTS-1:0][IDX_W-1:0]     own_idx, win_idx;
  logic [N_PORTS-1:0][N_PORTS-1:0]   owned_by;           // [in][out]

  for (genvar gi = 0; gi < N_PORTS; gi++) begin : g_in
    xbar_in_ctl #(.N_PORTS(N_PORTS)) u_in (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .valid_i      (in_valid_i[gi]),
      .last_i       (in_last_i[gi]),
      .route_i      (in_data_i[gi][IDX_W:0]),
      .gnt_i        (gnt_in[gi]),
      .path_ready_i (path_rdy[gi]),
      .ready_o      (in_ready_o[gi]),
      .req_o        (req[gi]),
      .req_ch_o     (req_ch[gi]),
      .lock_ch_o    (lock_ch[gi]),
      .drop_o       (drop[gi]),
      .err_o        (err_o[gi])
    );
  end

  for (genvar go = 0; go < N_PORTS; go++) begin : g_out
    xbar_rr_arb #(.N_PORTS(N_PORTS)) u_arb (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (!own_vld[go]),
      .req_i  (arb_req[go]),
      .gnt_o  (arb_gnt[go])
    );
  end

  // request fan-out, grant fan-in, ready back-path
  always_comb begin
    gnt_in   = '0;
    path_rdy = '0;
    for (int o = 0; o < N_PORTS; o++) begin
      for (int i = 0; i < N_PORTS; i++) begin
        arb_req[o][i] = req[i] && (req_ch[i] == IDX_W'(o));
        gnt_in[i]     = gnt_in[i] | arb_gnt[o][i];
        if (lock_ch[i] == IDX_W'(o)) path_rdy[i] = out_ready_i[o];
      end
    end
  end

  // data path mux
  always_comb begin
    for (int o = 0; o < N_PORTS; o++) begin
      out_valid_o[o] = 1'b0;
      out_data_o[o]  = '0;
      out_last_o[o]  = 1'b0;
      win_idx[o]     = '0;
      for (int i = 0; i < N_PORTS; i++) begin
        owned_by[i][o] = own_vld[o] && (own_idx[o] == IDX_W'(i));
        if (own_idx[o] == IDX_W'(i)) begin
          out_valid_o[o] = own_vld[o] && in_valid_i[i];
          out_data_o[o]  = in_data_i[i];
          out_last_o[o]  = in_last_i[i];
        end
        if (arb_gnt[o][i]) win_idx[o] = IDX_W'(i);
      end
    end
  end

  assign close = out_valid_o & out_ready_i & out_last_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      own_vld <= '0;
      own_idx <= '0;
    end else begin
      for (int o = 0; o < N_PORTS; o++) begin
        if (close[o]) own_vld[o] <= 1'b0;
        else if (|arb_gnt[o]) begin
          own_vld[o] <= 1'b1;
          own_idx[o] <= win_idx[o];
        end
      end
    end
  end

  for (genvar ga = 0; ga < N_PORTS; ga++) begin : g_chk
    // R3
    owner_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      own_vld[ga] && !close[ga] |=> own_vld[ga] && $stable(own_idx[ga]));
    // R3
    close_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      close[ga] |=> !own_vld[ga]);
    // R5
    one_path_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(owned_by[ga]));
    // R6
    drop_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      drop[ga] |-> (owned_by[ga] == '0));
  end
endmodule

// File: tb/tb_xbar_wormhole_switch.sv
`timescale 1ns/1ps
module tb_xbar_wormhole_switch;
  localparam int N = 14;
  localparam int W = 128;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic                 rst_n;
  logic [N-1:0]         in_valid, in_last, in_ready, out_valid, out_last, out_ready, err;
  logic [N-1:0][W-1:0]  in_data, out_data;

  xbar_wormhole_switch #(.N_PORTS(N), .DATA_W(W)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_data_i(in_data), .in_last_i(in_last),
    .in_ready_o(in_ready),
    .out_valid_o(out_valid), .out_data_o(out_data), .out_last_o(out_last),
    .out_ready_i(out_ready), .err_o(err)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  logic [W:0]   txq [N][$];
  logic [W-1:0] rxq [N][$];
  bit           acc [N];
  int           errcnt [N];
  bit [N-1:0]   stall = '0;
  bit           rdy_rand = 0;
  int           rdy_pct = 100;

  // behavioural model state
  int m_st [N];   // 0 head, 1 forwarding, 2 discarding
  int m_lock [N];
  int m_own [N];  // -1 free
  int m_ptr [N];
  bit m_err [N];

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] route(input int ch, input bit flip);
    logic [W-1:0] r;
    r = {$urandom, $urandom, $urandom, $urandom};
    r[3:0] = 4'(ch);
    r[4]   = (^r[3:0]) ^ flip;
    return r;
  endfunction

  function automatic logic [W-1:0] payload(input int src, input int seq);
    return {8'(src), 16'(seq), {13{8'hC3}}};
  endfunction

  task automatic send(input int src, input int ch, input int n, input bit flip);
    txq[src].push_back({(n == 0), route(ch, flip)});
    for (int k = 0; k < n; k++) txq[src].push_back({(k == n-1), payload(src, k)});
  endtask

  function automatic bit busy();
    for (int i = 0; i < N; i++)
      if (txq[i].size() != 0 || m_st[i] != 0 || m_own[i] >= 0) return 1;
    return 0;
  endfunction

  task automatic drain();
    @(negedge clk);
    while (busy()) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic clear_rx();
    for (int o = 0; o < N; o++) begin rxq[o].delete(); errcnt[o] = 0; end
  endtask

  // input and downstream-ready drivers
  always @(posedge clk) begin
    #1;
    for (int i = 0; i < N; i++) begin
      if (acc[i] && txq[i].size() != 0) void'(txq[i].pop_front());
      in_valid[i] = (txq[i].size() != 0);
      if (txq[i].size() != 0) {in_last[i], in_data[i]} = txq[i][0];
      else begin in_last[i] = 1'b0; in_data[i] = '0; end
    end
    for (int o = 0; o < N; o++)
      out_ready[o] = stall[o] ? 1'b0 :
                     (rdy_rand ? ($urandom_range(0, 99) < rdy_pct) : 1'b1);
  end

  // reference model, compared every cycle
  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        m_st[i] = 0; m_lock[i] = 0; m_own[i] = -1; m_ptr[i] = 0; m_err[i] = 0; acc[i] = 0;
      end
    end else begin
      int  n_st [N], n_lock [N], n_own [N], n_ptr [N], reqch [N];
      bit  n_err [N], e_rdy [N];
      for (int i = 0; i < N; i++) begin
        n_st[i] = m_st[i]; n_lock[i] = m_lock[i]; n_own[i] = m_own[i];
        n_ptr[i] = m_ptr[i]; n_err[i] = 0; e_rdy[i] = 0; reqch[i] = -1;
      end
      for (int i = 0; i < N; i++) begin
        if (m_st[i] == 0) begin
          if (in_valid[i]) begin
            int ch; bit bad;
            ch  = int'(in_data[i][3:0]);
            bad = (ch >= N) || (^in_data[i][4:0]);
            if (bad || in_last[i]) begin
              e_rdy[i] = 1;
              n_err[i] = bad;
              if (bad && !in_last[i]) n_st[i] = 2;
            end else reqch[i] = ch;
          end
        end else if (m_st[i] == 1) begin
          e_rdy[i] = out_ready[m_lock[i]];
          if (in_valid[i] && e_rdy[i] && in_last[i]) begin
            n_st[i] = 0; n_own[m_lock[i]] = -1;
          end
        end else begin
          e_rdy[i] = 1;
          if (in_valid[i] && in_last[i]) n_st[i] = 0;
        end
      end
      for (int o = 0; o < N; o++) begin
        if (m_own[o] < 0) begin
          for (int k = 0; k < N; k++) begin
            int idx;
            idx = (m_ptr[o] + k) % N;
            if (reqch[idx] == o) begin
              e_rdy[idx] = 1; n_st[idx] = 1; n_lock[idx] = o;
              n_own[o] = idx; n_ptr[o] = (idx + 1) % N;
              break;
            end
          end
        end
      end
      for (int i = 0; i < N; i++) begin
        chk(in_ready[i] == e_rdy[i], (m_st[i] == 1) ? "R7" : "R5",
            $sformatf("in_ready[%0d]", i), W'(in_ready[i]), W'(e_rdy[i]));
        chk(err[i] == m_err[i], "R6", $sformatf("err[%0d]", i), W'(err[i]), W'(m_err[i]));
        if (err[i]) errcnt[i]++;
        acc[i] = in_valid[i] && in_ready[i];
      end
      for (int o = 0; o < N; o++) begin
        bit ev;
        ev = (m_own[o] >= 0) && in_valid[(m_own[o] >= 0) ? m_own[o] : 0];
        chk(out_valid[o] == ev, "R3", $sformatf("out_valid[%0d]", o), W'(out_valid[o]), W'(ev));
        if (ev && out_valid[o]) begin
          chk(out_data[o] == in_data[m_own[o]], "R2", $sformatf("out_data[%0d]", o),
              out_data[o], in_data[m_own[o]]);
          chk(out_last[o] == in_last[m_own[o]], "R2", $sformatf("out_last[%0d]", o),
              W'(out_last[o]), W'(in_last[m_own[o]]));
        end
        if (out_valid[o] && out_ready[o]) rxq[o].push_back(out_data[o]);
      end
      for (int i = 0; i < N; i++) begin
        m_st[i] = n_st[i]; m_lock[i] = n_lock[i]; m_own[i] = n_own[i];
        m_ptr[i] = n_ptr[i]; m_err[i] = n_err[i];
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] casc;
    int expected;
    rst_n = 1'b0;
    in_valid = '0; in_last = '0; in_data = '0; out_ready = '1;
    for (int i = 0; i < N; i++) errcnt[i] = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == '0, "R1", "in_ready after reset", W'(in_ready), '0);
    chk(out_valid == '0, "R1", "out_valid after reset", W'(out_valid), '0);
    chk(err == '0, "R1", "err after reset", W'(err), '0);

    // R2 single frame, routing word stripped
    send(0, 5, 3, 0);
    drain();
    chk(rxq[5].size() == 3, "R2", "words on out 5", W'(rxq[5].size()), W'(3));
    for (int k = 0; k < 3 && k < rxq[5].size(); k++)
      chk(rxq[5][k] == payload(0, k), "R2", "payload order", rxq[5][k], payload(0, k));
    clear_rx();

    // R2 cascade: second word is a downstream routing word, passed intact
    casc = route(9, 0);
    txq[4].push_back({1'b0, route(2, 0)});
    txq[4].push_back({1'b0, casc});
    txq[4].push_back({1'b1, payload(4, 1)});
    drain();
    chk(rxq[2].size() == 2, "R2", "cascade word count", W'(rxq[2].size()), W'(2));
    if (rxq[2].size() > 0)
      chk(rxq[2][0] == casc, "R2", "cascade routing word", rxq[2][0], casc);
    clear_rx();

    // R4 contention, pointer starts at 0
    send(1, 7, 2, 0); send(2, 7, 2, 0); send(3, 7, 2, 0);
    drain();
    chk(rxq[7].size() == 6, "R4", "contention words", W'(rxq[7].size()), W'(6));
    if (rxq[7].size() == 6) begin
      chk(rxq[7][0][127:120] == 8'd1, "R4", "1st winner", W'(rxq[7][0][127:120]), W'(1));
      chk(rxq[7][2][127:120] == 8'd2, "R4", "2nd winner", W'(rxq[7][2][127:120]), W'(2));
      chk(rxq[7][4][127:120] == 8'd3, "R4", "3rd winner", W'(rxq[7][4][127:120]), W'(3));
    end
    clear_rx();
    // R4 pointer now at 4: order 10, 11, then wrap to 2
    send(2, 7, 1, 0); send(10, 7, 1, 0); send(11, 7, 1, 0);
    drain();
    chk(rxq[7].size() == 3, "R4", "rr words", W'(rxq[7].size()), W'(3));
    if (rxq[7].size() == 3) begin
      chk(rxq[7][0][127:120] == 8'd10, "R4", "rr first", W'(rxq[7][0][127:120]), W'(10));
      chk(rxq[7][1][127:120] == 8'd11, "R4", "rr second", W'(rxq[7][1][127:120]), W'(11));
      chk(rxq[7][2][127:120] == 8'd2, "R4", "rr wrap", W'(rxq[7][2][127:120]), W'(2));
    end
    clear_rx();

    // R7 stalled output holds its input; R5 second frame waits on a bound output
    stall[3] = 1'b1;
    send(6, 3, 2, 0); send(12, 3, 1, 0);
    repeat (10) @(negedge clk);
    chk(rxq[3].size() == 0, "R7", "nothing through stalled out", W'(rxq[3].size()), '0);
    chk(in_ready[6] == 1'b0, "R7", "stalled input ready", W'(in_ready[6]), '0);
    chk(in_ready[12] == 1'b0, "R5", "waiting input ready", W'(in_ready[12]), '0);
    stall[3] = 1'b0;
    drain();
    chk(rxq[3].size() == 3, "R5", "words after release", W'(rxq[3].size()), W'(3));
    clear_rx();

    // R6 bad parity and out-of-range channels
    send(8, 4, 2, 1);
    send(8, 14, 3, 0);
    send(9, 15, 1, 0);
    drain();
    chk(errcnt[8] == 2, "R6", "err pulses input 8", W'(errcnt[8]), W'(2));
    chk(errcnt[9] == 1, "R6", "err pulses input 9", W'(errcnt[9]), W'(1));
    begin
      int tot = 0;
      for (int o = 0; o < N; o++) tot += rxq[o].size();
      chk(tot == 0, "R6", "nothing forwarded", W'(tot), '0);
    end
    send(8, 4, 1, 0);
    drain();
    chk(rxq[4].size() == 1, "R6", "recovery after bad frame", W'(rxq[4].size()), W'(1));
    clear_rx();

    // R8 routing word that is also the last word
    send(9, 6, 0, 0);
    drain();
    chk(rxq[6].size() == 0 && errcnt[9] == 0, "R8", "lone routing word",
        W'(rxq[6].size() + errcnt[9]), '0);
    clear_rx();

    // mixed random traffic with random downstream ready
    rdy_rand = 1; rdy_pct = 70;
    expected = 0;
    for (int f = 0; f < 25; f++)
      for (int i = 0; i < N; i++) begin
        int ch, len; bit bad;
        ch  = $urandom_range(0, N-1);
        len = $urandom_range(1, 5);
        bad = ($urandom_range(0, 19) == 0);
        send(i, ch, len, bad);
        if (!bad) expected += len;
      end
    drain();
    rdy_rand = 0;
    begin
      int tot = 0;
      for (int o = 0; o < N; o++) tot += rxq[o].size();
      chk(tot == expected, "R2", "random traffic word count", W'(tot), W'(expected));
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule